// File: doc/BRIEF.md
# Nibble ALU with BCD Mode and Status Flags

This block is the arithmetic unit of a small 4-bit processor core. It takes a register operand `a_in`, a second operand `b_in` and an operation code. The result is computed combinationally and appears on `res_out`. A write strobe `wr_en` tells the register file whether to store that result. Four status flags are held in a register inside the block: carry, zero, decimal mode and interrupt enable. The flags are updated on the clock edge that accepts an operation, that is, any edge on which `op_valid` is high.

The operations are:
- add and subtract, each with or without the carry flag as carry-in or borrow-in;
- bitwise AND, OR and XOR;
- inversion;
- a right rotate through the carry flag;
- a compare and a zero test, which only touch the flags;
- eight single-flag set and clear operations.

While the decimal flag is set, all four add and subtract operations correct their result to packed BCD. The correction is only meaningful for operands from 0 to 9. Choosing registers and accessing memory are handled by the surrounding core.

Top module: `nib_alu_core`

## Requirements
- R1: After reset (`rst_n` low), carry, zero, decimal and interrupt-enable flags all read 0, and `wr_en` is 0 while `op_valid` is low.
- R2: Binary add: code 0 gives a+b and code 1 gives a+b+carry. The result is the low 4 bits, carry becomes the fifth bit of the sum, and `wr_en` is 1.
- R3: Binary subtract: code 2 gives a-b and code 3 gives a-b-carry. The result is the low 4 bits, and carry becomes 1 exactly when the difference is negative (a borrow).
- R4: With the decimal flag set, codes 0 and 1 check the raw sum. If it exceeds 9, the result is (sum+6) mod 16 and carry is set. Otherwise the result is the raw sum and carry is cleared.
- R5: With the decimal flag set, codes 2 and 3 check for a borrow. On a borrow, the result is (difference-6) mod 16 and carry is set. Otherwise the result is the plain difference and carry is cleared.
- R6: Codes 4 (AND), 5 (OR), 6 (XOR) and 9 (invert a) write their result. They set zero exactly when the result is 0 and leave carry unchanged.
- R7: Code 7 compares a with b. It sets carry on a borrow of a-b and zero when a equals b. It never applies decimal correction and keeps `wr_en` at 0.
- R8: Code 8 sets zero exactly when a AND b is 0. It leaves carry unchanged and keeps `wr_en` at 0.
- R9: Code 10 rotates right through carry: the result is {old carry, a[3:1]} and the new carry is a[0]. Zero follows the result.
- R10: Codes 16/17 set/clear carry, 18/19 set/clear zero, 20/21 set/clear decimal, and 22/23 set/clear interrupt enable. Each touches only its own flag.
- R11: While `op_valid` is low, or for an unassigned code (11 to 15, 24 to 31), no flag changes and `wr_en` is 0.
- R12: For every add and subtract, zero is set exactly when the 4-bit result written is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of all flags |
| op_valid | input | 1 | Operation accepted on this cycle |
| op_code | input | 5 | Operation selector |
| a_in | input | DATA_W | Register operand |
| b_in | input | DATA_W | Second operand (register or immediate) |
| res_out | output | DATA_W | Combinational result |
| wr_en | output | 1 | Result should be written back |
| carry_o | output | 1 | Carry / borrow flag |
| zero_o | output | 1 | Zero flag |
| dec_o | output | 1 | Decimal-mode flag |
| ie_o | output | 1 | Interrupt-enable flag |

## Verification
The properties run on every cycle and cover the following:
- the carry flag holding through logical operations and zero tests;
- the rotate moving bit 0 into carry;
- the zero flag tracking any written result;
- decimal additions of valid digits staying within 0 to 9;
- all flags freezing while idle.

Only the bench scenarios can show the actual arithmetic values:
- the +6 and -6 decimal corrections;
- the borrow polarity of subtraction;
- compare ignoring decimal mode;
- that each set or clear operation leaves the other three flags intact.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

   typedef enum logic [4:0] {
      OP_ADD  = 5'd0,
      OP_ADC  = 5'd1,
      OP_SUB  = 5'd2,
      OP_SBC  = 5'd3,
      OP_AND  = 5'd4,
      OP_OR   = 5'd5,
      OP_XOR  = 5'd6,
      OP_CMP  = 5'd7,
      OP_TST  = 5'd8,
      OP_INV  = 5'd9,
      OP_RRC  = 5'd10,
      OP_SETC = 5'd16,
      OP_CLRC = 5'd17,
      OP_SETZ = 5'd18,
      OP_CLRZ = 5'd19,
      OP_SETD = 5'd20,
      OP_CLRD = 5'd21,
      OP_SETI = 5'd22,
      OP_CLRI = 5'd23
   } alu_op_e;

   localparam int NUM_FLAGS = 4;
   localparam int FL_C = 0;
   localparam int FL_Z = 1;
   localparam int FL_D = 2;
   localparam int FL_I = 3;

   function automatic logic op_is_arith(input logic [4:0] op);
      return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) ||
             (op == OP_SBC) || (op == OP_CMP);
   endfunction

   function automatic logic op_is_logic(input logic [4:0] op);
      return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) ||
             (op == OP_TST) || (op == OP_INV) || (op == OP_RRC);
   endfunction

   function automatic logic op_writes(input logic [4:0] op);
      return op_is_arith(op) && (op != OP_CMP) ||
             op_is_logic(op) && (op != OP_TST);
   endfunction

   function automatic logic op_is_flagop(input logic [4:0] op);
      return op[4:3] == 2'b10;
   endfunction

endpackage

// File: rtl/nib_arith.sv
module nib_arith #(
   parameter int DATA_W = 4,
   parameter bit DEC_EN = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   input  logic              sub,
   input  logic              dec,
   output logic [DATA_W-1:0] res,
   output logic              cout
);
   localparam int XW = DATA_W + 1;
   localparam logic [XW-1:0] DEC_MAX = XW'(9);
   localparam logic [XW-1:0] DEC_ADJ = XW'(6);

   logic [XW-1:0] raw;

   always_comb begin
      if (sub) raw = {1'b0, a} - {1'b0, b} - XW'(cin);
      else     raw = {1'b0, a} + {1'b0, b} + XW'(cin);
   end

   generate
      if (DEC_EN) begin : g_dec
         if (DATA_W != 4) begin : g_bad_width
            $error("decimal correction needs a 4-bit datapath");
         end
         logic [XW-1:0] adj;
         always_comb begin
            adj  = raw;
            cout = raw[DATA_W];
            if (dec) begin
               if (sub) begin
                  if (raw[DATA_W]) adj = raw - DEC_ADJ;
               end else begin
                  cout = (raw > DEC_MAX);
                  if (raw > DEC_MAX) adj = raw + DEC_ADJ;
               end
            end
            res = adj[DATA_W-1:0];
         end
      end else begin : g_bin
         logic dec_unused;
         assign dec_unused = dec;
         assign res  = raw[DATA_W-1:0];
         assign cout = raw[DATA_W];
      end
   endgenerate

endmodule

// File: rtl/nib_logic.sv
module nib_logic
   import nib_alu_pkg::*;
#(
   parameter int DATA_W = 4
) (
   input  logic [4:0]        op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   output logic [DATA_W-1:0] res,
   output logic              cout
);
   always_comb begin
      res  = '0;
      cout = cin;
      case (op)
         OP_AND, OP_TST: res = a & b;
         OP_OR:          res = a | b;
         OP_XOR:         res = a ^ b;
         OP_INV:         res = ~a;
         OP_RRC: begin
            res  = {cin, a[DATA_W-1:1]};
            cout = a[0];
         end
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/nib_flags.sv
module nib_flags #(
   parameter int NFLAG = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] we,
   input  logic [NFLAG-1:0] d,
   output logic [NFLAG-1:0] q
);
   generate
      for (genvar i = 0; i < NFLAG; i++) begin : g_fl
         always_ff @(posedge clk) begin
            if (!rst_n)     q[i] <= 1'b0;
            else if (we[i]) q[i] <= d[i];
         end
      end
   endgenerate
endmodule

// File: rtl/nib_alu_core.sv
module nib_alu_core
   import nib_alu_pkg::*;
#(
   parameter int DATA_W = 4,
   parameter bit DEC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [4:0]        op_code,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] b_in,
   output logic [DATA_W-1:0] res_out,
   output logic              wr_en,
   output logic              carry_o,
   output logic              zero_o,
   output logic              dec_o,
   output logic              ie_o
);
   localparam int FIDX_W = $clog2(NUM_FLAGS);

   logic [NUM_FLAGS-1:0] fl_q, fl_we, fl_d;
   logic [DATA_W-1:0]    ar_res, lg_res;
   logic                 ar_cout, lg_cout;
   logic                 ar_sub, ar_cin, ar_dec;
   logic [FIDX_W-1:0]    fidx;

   always_comb begin
      ar_sub = (op_code == OP_SUB) || (op_code == OP_SBC) || (op_code == OP_CMP);
      ar_cin = ((op_code == OP_ADC) || (op_code == OP_SBC)) ? fl_q[FL_C] : 1'b0;
      ar_dec = fl_q[FL_D] && (op_code != OP_CMP);
   end

   nib_arith #(.DATA_W(DATA_W), .DEC_EN(DEC_EN)) u_arith (
      .a(a_in), .b(b_in), .cin(ar_cin), .sub(ar_sub), .dec(ar_dec),
      .res(ar_res), .cout(ar_cout)
   );

   nib_logic #(.DATA_W(DATA_W)) u_logic (
      .op(op_code), .a(a_in), .b(b_in), .cin(fl_q[FL_C]),
      .res(lg_res), .cout(lg_cout)
   );

   assign res_out = op_is_arith(op_code) ? ar_res : lg_res;
   assign wr_en   = op_valid && op_writes(op_code);
   assign fidx    = op_code[FIDX_W:1];

   always_comb begin
      fl_we = '0;
      fl_d  = '0;
      if (op_valid) begin
         if (op_is_arith(op_code)) begin
            fl_we[FL_C] = 1'b1;  fl_d[FL_C] = ar_cout;
            fl_we[FL_Z] = 1'b1;  fl_d[FL_Z] = (ar_res == '0);
         end else if (op_is_logic(op_code)) begin
            fl_we[FL_C] = 1'b1;  fl_d[FL_C] = lg_cout;
            fl_we[FL_Z] = 1'b1;  fl_d[FL_Z] = (lg_res == '0);
         end else if (op_is_flagop(op_code)) begin
            fl_we[fidx] = 1'b1;
            fl_d[fidx]  = ~op_code[0];
         end
      end
   end

   nib_flags #(.NFLAG(NUM_FLAGS)) u_flags (
      .clk(clk), .rst_n(rst_n), .we(fl_we), .d(fl_d), .q(fl_q)
   );

   assign carry_o = fl_q[FL_C];
   assign zero_o  = fl_q[FL_Z];
   assign dec_o   = fl_q[FL_D];
   assign ie_o    = fl_q[FL_I];

   // R6: logical operations keep the carry flag
   p_logic_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && (op_code inside {OP_AND, OP_OR, OP_XOR, OP_INV})
      |=> carry_o == $past(carry_o));

   // R8: the zero test keeps the carry flag
   p_tst_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_code == OP_TST |=> carry_o == $past(carry_o));

   // R9: the rotate moves bit 0 into carry
   p_rrc_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_code == OP_RRC |=> carry_o == $past(a_in[0]));

   // R12: the zero flag follows a written result
   p_zero_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> zero_o == ($past(res_out) == '0));

   // R4: decimal addition of valid digits stays a valid digit
   p_bcd_digit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && dec_o && (op_code inside {OP_ADD, OP_ADC}) &&
      (a_in <= DATA_W'(9)) && (b_in <= DATA_W'(9))
      |-> res_out <= DATA_W'(9));

   // R11: no flag moves while idle
   p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(carry_o) && $stable(zero_o) &&
                    $stable(dec_o) && $stable(ie_o));

endmodule

// File: tb/nib_alu_core_bench.sv
module nib_alu_core_bench;
   localparam int CLK_P = 10;
   localparam int NV    = 30;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [4:0] op_code = '0;
   logic [3:0] a_in = '0, b_in = '0;
   logic [3:0] res_out;
   logic       wr_en, carry_o, zero_o, dec_o, ie_o;

   int total = 0;
   int bad   = 0;

   always #(CLK_P/2) clk = ~clk;

   nib_alu_core u_nib_alu_core (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .a_in(a_in), .b_in(b_in), .res_out(res_out), .wr_en(wr_en),
      .carry_o(carry_o), .zero_o(zero_o), .dec_o(dec_o), .ie_o(ie_o)
   );

   // {op, a, b, carry_before, dec_before, result, wr, carry_after, zero_after}
   localparam logic [21:0] VEC [NV] = '{
      {5'd0,  4'h3, 4'h4, 1'b0, 1'b0, 4'h7, 1'b1, 1'b0, 1'b0},
      {5'd0,  4'h9, 4'h8, 1'b0, 1'b0, 4'h1, 1'b1, 1'b1, 1'b0},
      {5'd0,  4'h8, 4'h8, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 1'b1},
      {5'd1,  4'h5, 4'hA, 1'b1, 1'b0, 4'h0, 1'b1, 1'b1, 1'b1},
      {5'd1,  4'h2, 4'h3, 1'b0, 1'b0, 4'h5, 1'b1, 1'b0, 1'b0},
      {5'd2,  4'h7, 4'h3, 1'b0, 1'b0, 4'h4, 1'b1, 1'b0, 1'b0},
      {5'd2,  4'h3, 4'h5, 1'b0, 1'b0, 4'hE, 1'b1, 1'b1, 1'b0},
      {5'd3,  4'h5, 4'h5, 1'b1, 1'b0, 4'hF, 1'b1, 1'b1, 1'b0},
      {5'd3,  4'h6, 4'h2, 1'b1, 1'b0, 4'h3, 1'b1, 1'b0, 1'b0},
      {5'd0,  4'h5, 4'h7, 1'b0, 1'b1, 4'h2, 1'b1, 1'b1, 1'b0},
      {5'd0,  4'h9, 4'h9, 1'b0, 1'b1, 4'h8, 1'b1, 1'b1, 1'b0},
      {5'd0,  4'h4, 4'h5, 1'b0, 1'b1, 4'h9, 1'b1, 1'b0, 1'b0},
      {5'd1,  4'h9, 4'h0, 1'b1, 1'b1, 4'h0, 1'b1, 1'b1, 1'b1},
      {5'd2,  4'h3, 4'h5, 1'b0, 1'b1, 4'h8, 1'b1, 1'b1, 1'b0},
      {5'd2,  4'h9, 4'h4, 1'b0, 1'b1, 4'h5, 1'b1, 1'b0, 1'b0},
      {5'd3,  4'h0, 4'h0, 1'b1, 1'b1, 4'h9, 1'b1, 1'b1, 1'b0},
      {5'd4,  4'hC, 4'hA, 1'b1, 1'b0, 4'h8, 1'b1, 1'b1, 1'b0},
      {5'd5,  4'h0, 4'h0, 1'b1, 1'b0, 4'h0, 1'b1, 1'b1, 1'b1},
      {5'd6,  4'hF, 4'hF, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b1},
      {5'd6,  4'h5, 4'h3, 1'b1, 1'b1, 4'h6, 1'b1, 1'b1, 1'b0},
      {5'd9,  4'h5, 4'h0, 1'b0, 1'b0, 4'hA, 1'b1, 1'b0, 1'b0},
      {5'd9,  4'hF, 4'h0, 1'b1, 1'b0, 4'h0, 1'b1, 1'b1, 1'b1},
      {5'd7,  4'h3, 4'h5, 1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0},
      {5'd7,  4'h5, 4'h5, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1},
      {5'd7,  4'h9, 4'h3, 1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0},
      {5'd8,  4'hC, 4'h3, 1'b1, 1'b0, 4'h0, 1'b0, 1'b1, 1'b1},
      {5'd8,  4'h6, 4'h4, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0},
      {5'd10, 4'hB, 4'h0, 1'b0, 1'b0, 4'h5, 1'b1, 1'b1, 1'b0},
      {5'd10, 4'h1, 4'h0, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 1'b1},
      {5'd10, 4'h2, 4'h0, 1'b1, 1'b1, 4'h9, 1'b1, 1'b0, 1'b0}
   };

   function automatic string req_of(input logic [4:0] op, input logic dm);
      case (op)
         5'd0, 5'd1: return dm ? "R4" : "R2";
         5'd2, 5'd3: return dm ? "R5" : "R3";
         5'd7:       return "R7";
         5'd8:       return "R8";
         5'd10:      return "R9";
         default:    return "R6";
      endcase
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic issue(input logic [4:0] op, input logic [3:0] a, input logic [3:0] b);
      @(negedge clk);
      op_valid = 1'b1;
      op_code  = op;
      a_in     = a;
      b_in     = b;
   endtask

   task automatic idle();
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic preset(input logic c, input logic d);
      issue(c ? 5'd16 : 5'd17, 4'h0, 4'h0);
      step();
      issue(d ? 5'd20 : 5'd21, 4'h0, 4'h0);
      step();
   endtask

   initial begin
      #(CLK_P * 50000);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check("R1", "carry", carry_o, 0);
      check("R1", "zero",  zero_o,  0);
      check("R1", "dec",   dec_o,   0);
      check("R1", "ie",    ie_o,    0);
      check("R1", "wr_en", wr_en,   0);
      @(negedge clk);
      rst_n = 1'b1;

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [21:0] v;
         string r;
         v = VEC[i];
         r = req_of(v[21:17], v[7]);
         preset(v[8], v[7]);
         issue(v[21:17], v[16:13], v[12:9]);
         #1;
         check(r, "wr_en", wr_en, v[2]);
         if (v[2]) check(r, "result", res_out, v[6:3]);
         step();
         check(r, "carry", carry_o, v[1]);
         check(v[2] && r != "R6" && r != "R9" ? "R12" : r, "zero", zero_o, v[0]);
      end
      idle();

      // R10: each set/clear touches only its flag
      preset(1'b0, 1'b0);
      issue(5'd19, 4'h0, 4'h0); step();
      issue(5'd22, 4'h0, 4'h0); step();
      check("R10", "ie set", ie_o, 1);
      check("R10", "carry kept", carry_o, 0);
      check("R10", "dec kept", dec_o, 0);
      issue(5'd18, 4'h0, 4'h0); step();
      check("R10", "zero set", zero_o, 1);
      check("R10", "ie kept", ie_o, 1);
      issue(5'd16, 4'h0, 4'h0); step();
      issue(5'd20, 4'h0, 4'h0); step();
      check("R10", "carry set", carry_o, 1);
      check("R10", "dec set", dec_o, 1);
      issue(5'd23, 4'h0, 4'h0); step();
      check("R10", "ie clear", ie_o, 0);
      check("R10", "zero kept", zero_o, 1);
      issue(5'd17, 4'h0, 4'h0); step();
      check("R10", "carry clear", carry_o, 0);
      check("R10", "dec kept2", dec_o, 1);
      issue(5'd19, 4'h0, 4'h0); step();
      check("R10", "zero clear", zero_o, 0);
      issue(5'd21, 4'h0, 4'h0); step();
      check("R10", "dec clear", dec_o, 0);

      // R11: idle cycle with an add presented
      @(negedge clk);
      op_valid = 1'b0; op_code = 5'd0; a_in = 4'hF; b_in = 4'h1;
      #1;
      check("R11", "idle wr_en", wr_en, 0);
      step();
      check("R11", "idle carry", carry_o, 0);
      check("R11", "idle zero",  zero_o,  0);
      // R11: unassigned codes
      issue(5'd13, 4'hF, 4'h1);
      #1;
      check("R11", "code13 wr_en", wr_en, 0);
      step();
      issue(5'd26, 4'h0, 4'h0);
      #1;
      check("R11", "code26 wr_en", wr_en, 0);
      step();
      check("R11", "unassigned carry", carry_o, 0);
      check("R11", "unassigned zero",  zero_o,  0);
      check("R11", "unassigned dec",   dec_o,   0);
      check("R11", "unassigned ie",    ie_o,    0);

      // R1: reset in mid-run clears set flags
      issue(5'd16, 4'h0, 4'h0); step();
      issue(5'd22, 4'h0, 4'h0); step();
      idle();
      rst_n = 1'b0;
      step();
      check("R1", "reset carry", carry_o, 0);
      check("R1", "reset ie",    ie_o,    0);
      @(negedge clk);
      rst_n = 1'b1;

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule